// File: doc/BRIEF.md
# Interrupt Status Collector

This block keeps the interrupt state of a storage host controller. Event pulses from the controller's command, data and card-detect logic set bits in a 32-bit raw status register. A 32-bit mask register selects which pending bits may interrupt the processor, and a masked view gives raw status ANDed with the mask. Software acknowledges an event by writing a one to the bit, at either the raw or the masked status address. A single registered interrupt line is raised when the enable bit of the global control register is set and at least one unmasked bit is pending.

The block also keeps a separate DMA status register. Transmit and receive completion pulses set its bits, and software clears them by writing ones, but only within the low ten bits. A card-present status bit follows the insert and remove events. Register reads are combinational through a dedicated read address. Writes take effect on the next clock edge.

Top module: `irq_status_unit`

## Requirements
- R1: After reset: global control reads 0x300, status reads 0x100, mask, raw status, masked status and DMA status read 0, and irqOut is 0. Word addresses: 0 control, 1 mask, 2 masked status, 3 raw status, 4 status, 5 DMA status.
- R2: A one on bit k of evtSet sets raw status bit k on the next edge, for every k except 30 and 31. Raw status reads at address 3.
- R3: Address 2 reads raw status AND mask.
- R4: A write to address 2 or address 3 clears every raw status bit that is written as 1 and leaves the others unchanged.
- R5: An event on a bit in the same cycle as a software clear of that bit leaves the bit set.
- R6: A write to global control stores the written value with bits 2, 1 and 0 forced to zero.
- R7: irqOut is 1 one cycle after global control bit 4 is 1 and (raw AND mask) is non-zero. Otherwise it is 0 one cycle later.
- R8: cardIns sets raw bit 30, clears raw bit 31 and sets status bit 8. cardRem sets raw bit 31, clears raw bit 30 and clears status bit 8. If both arrive in the same cycle, the insertion wins.
- R9: dmaTxDone sets DMA status bits 0 and 8. dmaRxDone sets DMA status bits 1 and 8.
- R10: A write to address 5 clears the DMA status bits among positions 9:0 that are written as 1 and leaves bits 31:10 unchanged.
- R11: A write to the mask (address 1) stores the whole word and reads back unchanged.
- R12: Addresses 6 and 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Word address of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Word address of the combinational read |
| rdData | output | 32 | Read data |
| evtSet | input | 32 | Event pulses that set raw status bits (bits 30 and 31 are ignored) |
| cardIns | input | 1 | Card insertion pulse |
| cardRem | input | 1 | Card removal pulse |
| dmaTxDone | input | 1 | DMA transmit completion pulse |
| dmaRxDone | input | 1 | DMA receive completion pulse |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 3-bit address and a 10-bit DMA clear field. The 3-bit address leaves two unused codes, so the bench can check that reads and writes there are harmless. The 10-bit clear field puts the DMA summary bit inside the clearable range, so the bench can show that a high write is ignored and that bit 8 still clears. The 32-bit word gives access to the card bits at positions 30 and 31, and to the same-cycle event and clear ordering on both status addresses.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 3;

  // word addresses
  localparam logic [ADDR_W-1:0] A_CTL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASKED = 3'd2;
  localparam logic [ADDR_W-1:0] A_RAW    = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd4;
  localparam logic [ADDR_W-1:0] A_DMA    = 3'd5;

  // bit positions the behaviour depends on
  localparam int unsigned B_IRQ_EN  = 4;
  localparam int unsigned B_INSERT  = 30;
  localparam int unsigned B_REMOVE  = 31;
  localparam int unsigned B_PRESENT = 8;
  localparam int unsigned B_DMA_TX  = 0;
  localparam int unsigned B_DMA_RX  = 1;
  localparam int unsigned B_DMA_SUM = 8;
  localparam int unsigned SELF_CLR_W = 3;

  localparam logic [WORD_W-1:0] CTL_RST  = 32'h0000_0300;
  localparam logic [WORD_W-1:0] STAT_RST = 32'h0000_0100;

  typedef struct packed {
    logic wrCtl;
    logic wrMask;
    logic clrRaw;
    logic clrDma;
  } regStrobe_t;
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe = '0;
    if (wrEn) begin
      unique case (wrAddr)
        A_CTL:            strobe.wrCtl  = 1'b1;
        A_MASK:           strobe.wrMask = 1'b1;
        A_MASKED, A_RAW:  strobe.clrRaw = 1'b1;
        A_DMA:            strobe.clrDma = 1'b1;
        default:          strobe = '0;
      endcase
    end
  end

  // R4: both status addresses produce the clear strobe
  a_r4_dual_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr == A_MASKED || wrAddr == A_RAW)) |-> strobe.clrRaw);

  // R12: unused addresses raise no strobe; at most one strobe at a time
  a_r12_no_stray: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe) && (!(wrEn && wrAddr > A_DMA) || strobe == '0));
endmodule

// File: rtl/irq_status_datapath.sv
module irq_status_datapath
  import irq_status_pkg::*;
#(
  parameter int unsigned DMA_CLR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  input  logic [WORD_W-1:0] evtSet,
  input  logic              cardIns,
  input  logic              cardRem,
  input  logic              dmaTxDone,
  input  logic              dmaRxDone,
  output logic              irqOut
);
  localparam logic [WORD_W-1:0] CARD_BITS = (WORD_W'(1) << B_INSERT) | (WORD_W'(1) << B_REMOVE);
  localparam logic [WORD_W-1:0] DMA_CLR_FIELD = WORD_W'((64'd1 << DMA_CLR_W) - 64'd1);
  localparam logic [WORD_W-1:0] SELF_CLR = WORD_W'((64'd1 << SELF_CLR_W) - 64'd1);

  logic [WORD_W-1:0] ctlQ, maskQ, rawQ, statQ, dmaQ;
  logic [WORD_W-1:0] rawD, statD, dmaD, dmaSet, evtUse, rawClr;

  assign evtUse = evtSet & ~CARD_BITS;
  assign rawClr = strobe.clrRaw ? wrData : '0;

  // raw status: clear first, then events override (event wins)
  always_comb begin
    rawD  = (rawQ & ~rawClr) | evtUse;
    statD = statQ;
    if (cardIns) begin
      rawD[B_INSERT]     = 1'b1;
      rawD[B_REMOVE]     = 1'b0;
      statD[B_PRESENT]   = 1'b1;
    end else if (cardRem) begin
      rawD[B_INSERT]     = 1'b0;
      rawD[B_REMOVE]     = 1'b1;
      statD[B_PRESENT]   = 1'b0;
    end
  end

  always_comb begin
    dmaSet = '0;
    if (dmaTxDone) begin
      dmaSet[B_DMA_TX]  = 1'b1;
      dmaSet[B_DMA_SUM] = 1'b1;
    end
    if (dmaRxDone) begin
      dmaSet[B_DMA_RX]  = 1'b1;
      dmaSet[B_DMA_SUM] = 1'b1;
    end
    dmaD = dmaQ;
    if (strobe.clrDma) dmaD = dmaQ & ~(wrData & DMA_CLR_FIELD);
    dmaD = dmaD | dmaSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ   <= CTL_RST;
      maskQ  <= '0;
      rawQ   <= '0;
      statQ  <= STAT_RST;
      dmaQ   <= '0;
      irqOut <= 1'b0;
    end else begin
      if (strobe.wrCtl)  ctlQ  <= wrData & ~SELF_CLR;
      if (strobe.wrMask) maskQ <= wrData;
      rawQ   <= rawD;
      statQ  <= statD;
      dmaQ   <= dmaD;
      irqOut <= ctlQ[B_IRQ_EN] & (|(rawQ & maskQ));
    end
  end

  always_comb begin
    unique case (rdAddr)
      A_CTL:    rdData = ctlQ;
      A_MASK:   rdData = maskQ;
      A_MASKED: rdData = rawQ & maskQ;
      A_RAW:    rdData = rawQ;
      A_STAT:   rdData = statQ;
      A_DMA:    rdData = dmaQ;
      default:  rdData = '0;
    endcase
  end

  // R5: an event bit is always present after the edge, whatever the clear
  a_r5_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|evtUse) |=> ((rawQ & $past(evtUse)) == $past(evtUse)));

  // R7: interrupt timing against enable and pending masked bits
  a_r7_irq_raise: assert property (@(posedge clk) disable iff (!rstN)
    (ctlQ[B_IRQ_EN] && (|(rawQ & maskQ))) |=> irqOut);
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlQ[B_IRQ_EN]) |=> !irqOut);

  // R8: insert and remove flags never pending together
  a_r8_card_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rawQ[B_INSERT] && rawQ[B_REMOVE]));
  a_r8_present_follows: assert property (@(posedge clk) disable iff (!rstN)
    cardIns |=> statQ[B_PRESENT]);

  // R10: high DMA bits unaffected by a clear write
  a_r10_dma_high_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrDma |=> (dmaQ & ~DMA_CLR_FIELD) == ($past(dmaQ) & ~DMA_CLR_FIELD));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int unsigned DMA_CLR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  input  logic [WORD_W-1:0] evtSet,
  input  logic              cardIns,
  input  logic              cardRem,
  input  logic              dmaTxDone,
  input  logic              dmaRxDone,
  output logic              irqOut
);
  regStrobe_t strobe;

  irq_status_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strobe (strobe)
  );

  irq_status_datapath #(.DMA_CLR_W(DMA_CLR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .evtSet    (evtSet),
    .cardIns   (cardIns),
    .cardRem   (cardRem),
    .dmaTxDone (dmaTxDone),
    .dmaRxDone (dmaRxDone),
    .irqOut    (irqOut)
  );
endmodule

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [31:0] evtSet = '0;
  logic        cardIns = 1'b0, cardRem = 1'b0, dmaTxDone = 1'b0, dmaRxDone = 1'b0;
  logic        irqOut;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_status_unit dut (.*);

  typedef struct packed {
    logic        we;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] evt;
    logic [2:0]  chkAddr;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 32'h0,         32'h0000_000C, 3'd3, 32'h0000_000C}, // R2
    '{1'b1, 3'd1, 32'h0000_0004, 32'h0,         3'd2, 32'h0000_0004}, // R3
    '{1'b1, 3'd3, 32'h0000_0004, 32'h0,         3'd3, 32'h0000_0008}, // R4 raw addr
    '{1'b1, 3'd2, 32'h0000_0008, 32'h0000_0004, 3'd3, 32'h0000_0004}, // R4 masked addr
    '{1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0,         3'd0, 32'hFFFF_FFF8}, // R6
    '{1'b1, 3'd0, 32'h0000_0010, 32'h0,         3'd0, 32'h0000_0010}, // R6
    '{1'b1, 3'd3, 32'h0000_0001, 32'h0000_0001, 3'd3, 32'h0000_0005}, // R5
    '{1'b1, 3'd1, 32'hA5A5_5A5A, 32'h0,         3'd1, 32'hA5A5_5A5A}, // R11
    '{1'b1, 3'd2, 32'hFFFF_FFFF, 32'hC000_0000, 3'd3, 32'h0000_0000}  // R2 bits 30/31 ignored, R4
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [31:0] exp);
    rdAddr = a;
    #1;
    chk(req, rdData, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, "R1 ctl", 32'h300);
    rd(3'd1, "R1 mask", 32'h0);
    rd(3'd2, "R1 masked", 32'h0);
    rd(3'd3, "R1 raw", 32'h0);
    rd(3'd4, "R1 status", 32'h100);
    rd(3'd5, "R1 dma", 32'h0);
    chk("R1 irq", {31'b0, irqOut}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wrEn = VECS[i].we; wrAddr = VECS[i].addr; wrData = VECS[i].data; evtSet = VECS[i].evt;
      @(negedge clk);
      wrEn = 1'b0; evtSet = '0;
      rd(VECS[i].chkAddr, $sformatf("R2-R6 vector %0d", i), VECS[i].exp);
    end

    // R7: enable is set (0x10), mask 0xA5A55A5A, raw 0; set bit 1 (masked in)
    @(negedge clk); evtSet = 32'h2;
    @(negedge clk); evtSet = '0;
    chk("R7 irq not yet", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    chk("R7 irq raised", {31'b0, irqOut}, 32'h1);
    wr(3'd0, 32'h0);           // disable
    chk("R7 irq still high", {31'b0, irqOut}, 32'h1);
    @(negedge clk);
    chk("R7 irq gated", {31'b0, irqOut}, 32'h0);
    wr(3'd0, 32'h10);
    @(negedge clk);
    chk("R7 irq re-enabled", {31'b0, irqOut}, 32'h1);
    wr(3'd3, 32'h2);
    @(negedge clk);
    chk("R7 irq after clear", {31'b0, irqOut}, 32'h0);

    // R8 card events
    @(negedge clk); cardRem = 1'b1;
    @(negedge clk); cardRem = 1'b0;
    rd(3'd3, "R8 remove raw", 32'h8000_0000);
    rd(3'd4, "R8 remove status", 32'h0);
    @(negedge clk); cardIns = 1'b1;
    @(negedge clk); cardIns = 1'b0;
    rd(3'd3, "R8 insert raw", 32'h4000_0000);
    rd(3'd4, "R8 insert status", 32'h100);
    @(negedge clk); cardRem = 1'b1;
    @(negedge clk); cardRem = 1'b0;
    @(negedge clk); cardIns = 1'b1; cardRem = 1'b1;
    @(negedge clk); cardIns = 1'b0; cardRem = 1'b0;
    rd(3'd3, "R8 both insert wins", 32'h4000_0000);
    rd(3'd4, "R8 both status", 32'h100);
    wr(3'd3, 32'hFFFF_FFFF);

    // R9/R10 DMA status
    @(negedge clk); dmaTxDone = 1'b1;
    @(negedge clk); dmaTxDone = 1'b0;
    rd(3'd5, "R9 tx", 32'h101);
    @(negedge clk); dmaRxDone = 1'b1;
    @(negedge clk); dmaRxDone = 1'b0;
    rd(3'd5, "R9 rx", 32'h103);
    wr(3'd5, 32'h1);
    rd(3'd5, "R10 clear tx", 32'h102);
    wr(3'd5, 32'hFFFF_FC00);
    rd(3'd5, "R10 high write ignored", 32'h102);
    wr(3'd5, 32'h100);
    rd(3'd5, "R10 clear summary", 32'h2);

    // R12 unused addresses
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, "R12 read 6", 32'h0);
    rd(3'd7, "R12 read 7", 32'h0);
    rd(3'd0, "R12 ctl kept", 32'h10);
    rd(3'd1, "R12 mask kept", 32'hA5A5_5A5A);
    rd(3'd3, "R12 raw kept", 32'h0);
    rd(3'd5, "R12 dma kept", 32'h2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule